// File: doc/BRIEF.md
# Camera pixel output formatter

This block sits after the lane merger and depacketizer of a camera receiver. It takes one pixel or one colour component per input beat and places it onto a parallel output word. The word is 8, 16 or 24 bits wide, and a strobe marks each valid word. Each stream format has a fixed bit layout, with the unused bits filled with zeros. YUV422 components are paired in one of two byte orders. Narrow RAW pixels can be packed several to a word when the bus is 24 bits wide. Frame-valid and line-valid travel with the data, so the receiving interface sees aligned markers.

Firmware sets the format and bus width through static configuration inputs. These are taken up only between frames. The output word is registered, and it appears one clock after the beat that completes it. A line that ends with a partly filled packed word still delivers that word, zero-padded.

Top module: `pixel_out_formatter`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first input beat, `out_strobe`, `out_fv`, `out_lv` and `out_data` are all zero.
- R2: Single-component formats produce one word per beat (`in_valid` and `in_lv` both high), one clock later. The output is the low bits of `in_data`, zero-extended:
  - RAW8 (`cfg_fmt`=0): 8 bits.
  - RAW10 (1): 10 bits.
  - RAW12 (2): 12 bits.
  - RAW14 (3): 14 bits.
  - YUV422 byte-wide (10): 8 bits, components passed in arrival order U,Y,V,Y.
  - YUV422 10-bit (13): 10 bits.
- R3: RGB888 (4) passes `in_data[23:0]` unchanged. For RGB666 the input is R=`in_data[17:12]`, G=`[11:6]`, B=`[5:0]`:
  - Padded layout (5): {2'b0,R,2'b0,G,2'b0,B}.
  - Compact layout (6): {6'b0,R,G,B}.
- R4: For RGB565 the input is R=`in_data[15:11]`, G=`[10:5]`, B=`[4:0]`:
  - Layout (7): {2'b0,R,3'b0,G,2'b0,B,1'b0}.
  - Layout (8): {3'b0,R,2'b0,G,3'b0,B}.
  - 16-bit layout (9): {8'b0,R,G,B}.
- R5: YUV422 16-bit modes take `in_data[7:0]` on two beats and emit one word after the second beat, with no strobe after the first. Chroma-first (11) gives {8'b0,first,second}. Luma-first (12) gives {8'b0,second,first}.
- R6: With `cfg_bus`=2 (24 bits), RAW8 packs three pixels per word at 8-bit slots. RAW10 and RAW12 pack two pixels per word at 12-bit slots. The earliest pixel is in the lowest slot, and the strobe rises only when the word is full.
- R7: The output is cut to the selected bus: `cfg_bus`=0 forces `out_data[23:8]` to zero and `cfg_bus`=1 forces `out_data[23:16]` to zero.
- R8: When `in_lv` falls with a packed word partly filled, that word is emitted zero-padded one clock later. `out_lv` is held high for that one extra cycle.
- R9: Beats with `in_lv` low are ignored, and the packing slot restarts at slot 0 at every line start.
- R10: Changes on `cfg_fmt`/`cfg_bus` take effect only on a clock edge where `in_fv` is low. During a frame the old setting stays in force.
- R11: `out_fv` and `out_lv` follow `in_fv` and `in_lv` one clock later, aligned with the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat carries a pixel or component |
| in_data | input | 24 | Unpacked pixel or component |
| in_fv | input | 1 | Input frame-valid |
| in_lv | input | 1 | Input line-valid |
| cfg_fmt | input | 4 | Stream format code |
| cfg_bus | input | 2 | Bus width: 0=8, 1=16, 2 or 3=24 bits |
| out_data | output | 24 | Output word |
| out_strobe | output | 1 | Output word valid |
| out_fv | output | 1 | Output frame-valid |
| out_lv | output | 1 | Output line-valid |

## Verification
The bench goes after these corner cases:
- **Padding bit positions.** The two padded RGB layouts place each colour at a distinct offset. A swapped shift or field would move a colour into the wrong byte.
- **YUV pairing order.** The two 16-bit YUV modes must keep luma and chroma in their own bytes; a reversed pairing would swap them.
- **Packing.** Packing must keep the earliest pixel in the lowest slot, and must not raise the strobe on a partly filled word.
- **Line-end flush.** A design that dropped the partial word would lose pixels at line end.
- **Slot restart.** One that kept the slot counter across lines would misalign the next line.
- **Configuration and ignored beats.** A design that applied a configuration change mid-frame would corrupt the words that follow. One that counted beats outside the line would shift every later pixel.

// File: rtl/pixel_out_formatter.sv
module pixel_out_formatter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [23:0] in_data,
  input  logic        in_fv,
  input  logic        in_lv,
  input  logic [3:0]  cfg_fmt,
  input  logic [1:0]  cfg_bus,
  output logic [23:0] out_data,
  output logic        out_strobe,
  output logic        out_fv,
  output logic        out_lv
);
  localparam logic [3:0] F_RAW8 = 4'd0, F_RAW10 = 4'd1, F_RAW12 = 4'd2, F_RAW14 = 4'd3;
  localparam logic [3:0] F_RGB888 = 4'd4, F_666P = 4'd5, F_666C = 4'd6;
  localparam logic [3:0] F_565A = 4'd7, F_565B = 4'd8, F_565N = 4'd9;
  localparam logic [3:0] F_YUV8 = 4'd10, F_YUVCF = 4'd11, F_YUVLF = 4'd12, F_YUV10 = 4'd13;

  logic [3:0]  fmt_r;
  logic [1:0]  bus_r;
  logic        lv_q;
  logic [1:0]  cnt;
  logic [23:0] acc;
  logic [1:0]  pack_n;
  logic        slot12;
  logic [23:0] comp;

  wire wide = bus_r[1];

  always_ff @(posedge clk)
    if (!rst_n) begin
      fmt_r <= F_RAW8;
      bus_r <= 2'd0;
    end else if (!in_fv) begin
      fmt_r <= cfg_fmt;
      bus_r <= cfg_bus;
    end

  always_comb begin
    pack_n = 2'd1;
    slot12 = 1'b0;
    case (fmt_r)
      F_RAW8:           if (wide) pack_n = 2'd3;
      F_RAW10, F_RAW12: if (wide) begin pack_n = 2'd2; slot12 = 1'b1; end
      F_YUVCF, F_YUVLF: pack_n = 2'd2;
      default:          pack_n = 2'd1;
    endcase
  end

  always_comb
    case (fmt_r)
      F_RAW8, F_YUV8, F_YUVCF, F_YUVLF: comp = {16'b0, in_data[7:0]};
      F_RAW10, F_YUV10: comp = {14'b0, in_data[9:0]};
      F_RAW12:  comp = {12'b0, in_data[11:0]};
      F_RAW14:  comp = {10'b0, in_data[13:0]};
      F_RGB888: comp = in_data;
      F_666P:   comp = {2'b0, in_data[17:12], 2'b0, in_data[11:6], 2'b0, in_data[5:0]};
      F_666C:   comp = {6'b0, in_data[17:0]};
      F_565A:   comp = {2'b0, in_data[15:11], 3'b0, in_data[10:5], 2'b0, in_data[4:0], 1'b0};
      F_565B:   comp = {3'b0, in_data[15:11], 2'b0, in_data[10:5], 3'b0, in_data[4:0]};
      F_565N:   comp = {8'b0, in_data[15:0]};
      default:  comp = 24'b0;
    endcase

  wire        beat    = in_valid && in_lv;
  wire [1:0]  cur_cnt = lv_q ? cnt : 2'd0;
  wire [23:0] cur_acc = lv_q ? acc : 24'd0;
  wire [4:0]  sh      = slot12 ? {3'b0, cur_cnt} * 5'd12 : {3'b0, cur_cnt} * 5'd8;
  wire [23:0] merged  = cur_acc | (comp << sh);
  wire        flush   = lv_q && !in_lv && (cnt != 2'd0);
  wire        full    = beat && (cur_cnt == pack_n - 2'd1);
  wire [23:0] word    = full ? merged : acc;
  wire [23:0] ordered = (fmt_r == F_YUVCF) ? {8'b0, word[7:0], word[15:8]} : word;
  wire [23:0] masked  = (bus_r == 2'd0) ? {16'b0, ordered[7:0]} :
                        (bus_r == 2'd1) ? {8'b0, ordered[15:0]} : ordered;

  always_ff @(posedge clk)
    if (!rst_n) begin
      lv_q       <= 1'b0;
      cnt        <= 2'd0;
      acc        <= 24'd0;
      out_data   <= 24'd0;
      out_strobe <= 1'b0;
      out_fv     <= 1'b0;
      out_lv     <= 1'b0;
    end else begin
      lv_q       <= in_lv;
      out_fv     <= in_fv || flush;
      out_lv     <= in_lv || flush;
      out_strobe <= full || flush;
      if (full || flush) out_data <= masked;
      if (full || flush) begin
        cnt <= 2'd0;
        acc <= 24'd0;
      end else if (beat) begin
        cnt <= cur_cnt + 2'd1;
        acc <= merged;
      end
    end

  assert_strobe_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> out_lv);
  assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> ($past(in_valid && in_lv) || $past(lv_q && !in_lv)));
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_fv |=> ($stable(fmt_r) && $stable(bus_r)));
  assert_narrow_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && bus_r == 2'd0 && $past(bus_r) == 2'd0) |-> out_data[23:8] == 16'd0);
  assert_fv_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_fv) |-> out_fv);
endmodule

// File: tb/pixel_out_formatter_test.sv
module pixel_out_formatter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_fv = 1'b0, in_lv = 1'b0;
  logic [23:0] in_data = 24'd0;
  logic [3:0] cfg_fmt = 4'd0;
  logic [1:0] cfg_bus = 2'd0;
  logic [23:0] out_data;
  logic out_strobe, out_fv, out_lv;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  pixel_out_formatter uut (.*);

  // {fmt, bus, in_data, expected}
  localparam logic [53:0] VEC [15] = '{
    {4'd0,  2'd0, 24'h1234A5, 24'h0000A5},  // R2 raw8
    {4'd1,  2'd1, 24'hFFF3A5, 24'h0003A5},  // R2 raw10
    {4'd2,  2'd1, 24'hFFFABC, 24'h000ABC},  // R2 raw12
    {4'd3,  2'd1, 24'hFF3ABC, 24'h003ABC},  // R2 raw14
    {4'd10, 2'd0, 24'h55667A, 24'h00007A},  // R2 yuv byte
    {4'd13, 2'd1, 24'hFFF2C1, 24'h0002C1},  // R2 yuv10
    {4'd4,  2'd2, 24'hA1B2C3, 24'hA1B2C3},  // R3 rgb888
    {4'd5,  2'd2, 24'hFEA57F, 24'h2A153F},  // R3 666 padded
    {4'd6,  2'd2, 24'hFEA57F, 24'h02A57F},  // R3 666 compact
    {4'd7,  2'd2, 24'h77AD4F, 24'h2A2A1E},  // R4 565 A
    {4'd8,  2'd2, 24'h77AD4F, 24'h152A0F},  // R4 565 B
    {4'd9,  2'd1, 24'h77AD4F, 24'h00AD4F},  // R4 565 16
    {4'd4,  2'd0, 24'hA1B2C3, 24'h0000C3},  // R7 bus 8
    {4'd4,  2'd1, 24'hA1B2C3, 24'h00B2C3},  // R7 bus 16
    {4'd3,  2'd0, 24'hFF3ABC, 24'h0000BC}   // R7 bus 8 raw14
  };
  localparam int VREQ [15] = '{2,2,2,2,2,2,3,3,3,4,4,4,7,7,7};

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic idle_cfg(input logic [3:0] f, input logic [1:0] b);
    @(negedge clk);
    in_fv = 0; in_lv = 0; in_valid = 0; cfg_fmt = f; cfg_bus = b;
    @(negedge clk);
  endtask

  task automatic drive(input logic fv, input logic lv, input logic v, input logic [23:0] d);
    @(negedge clk);
    in_fv = fv; in_lv = lv; in_valid = v; in_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 strobe", {23'd0, out_strobe}, 24'd0);
    chk("R1 data", out_data, 24'd0);
    chk("R1 markers", {22'd0, out_fv, out_lv}, 24'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", {21'd0, out_strobe, out_fv, out_lv}, 24'd0);

    for (int i = 0; i < 15; i++) begin
      idle_cfg(VEC[i][53:50], VEC[i][49:48]);
      drive(1, 0, 0, 24'd0);
      if (i == 0) chk("R11 fv before line", {22'd0, out_fv, out_lv}, 24'd2);
      drive(1, 1, 1, VEC[i][47:24]);
      chk($sformatf("R%0d vec %0d strobe", VREQ[i], i), {23'd0, out_strobe}, 24'd1);
      chk($sformatf("R%0d vec %0d data", VREQ[i], i), out_data, VEC[i][23:0]);
      if (i == 0) chk("R11 lv aligned", {23'd0, out_lv}, 24'd1);
      drive(1, 0, 0, 24'd0);
      drive(0, 0, 0, 24'd0);
      if (i == 0) chk("R11 markers drop", {22'd0, out_fv, out_lv}, 24'd0);
    end

    // R5 chroma-first and luma-first pairing
    for (int m = 0; m < 2; m++) begin
      idle_cfg(m == 0 ? 4'd11 : 4'd12, 2'd1);
      drive(1, 0, 0, 24'd0);
      drive(1, 1, 1, 24'hFF0011);
      chk("R5 no strobe on half", {23'd0, out_strobe}, 24'd0);
      drive(1, 1, 1, 24'hFF0022);
      chk("R5 pair 1", out_data, m == 0 ? 24'h001122 : 24'h002211);
      drive(1, 1, 1, 24'h000033);
      drive(1, 1, 1, 24'h000044);
      chk("R5 pair 2", out_data, m == 0 ? 24'h003344 : 24'h004433);
      drive(1, 0, 0, 24'd0);
      drive(0, 0, 0, 24'd0);
    end

    // R6 raw8 triple pack
    idle_cfg(4'd0, 2'd2);
    drive(1, 0, 0, 24'd0);
    drive(1, 1, 1, 24'h0000A1);
    chk("R6 no strobe slot0", {23'd0, out_strobe}, 24'd0);
    drive(1, 1, 1, 24'h0000B2);
    chk("R6 no strobe slot1", {23'd0, out_strobe}, 24'd0);
    drive(1, 1, 1, 24'h0000C3);
    chk("R6 raw8 packed", out_data, 24'hC3B2A1);

    // R8 flush of partial word, R9 ignored beat and slot restart
    drive(1, 1, 1, 24'h000011);
    drive(1, 1, 1, 24'h000022);
    chk("R8 partial not yet out", {23'd0, out_strobe}, 24'd0);
    drive(1, 0, 0, 24'd0);
    chk("R8 flush strobe", {23'd0, out_strobe}, 24'd1);
    chk("R8 flush data", out_data, 24'h002211);
    chk("R8 lv stretched", {23'd0, out_lv}, 24'd1);
    drive(1, 0, 1, 24'h000099);
    chk("R9 beat outside line ignored", {22'd0, out_strobe, out_lv}, 24'd0);
    drive(1, 1, 1, 24'h000033);
    drive(1, 1, 1, 24'h000044);
    drive(1, 1, 1, 24'h000055);
    chk("R9 slot restart", out_data, 24'h554433);
    drive(1, 0, 0, 24'd0);
    chk("R8 no flush when empty", {23'd0, out_strobe}, 24'd0);
    drive(0, 0, 0, 24'd0);

    // R6 raw10 pair pack
    idle_cfg(4'd1, 2'd2);
    drive(1, 0, 0, 24'd0);
    drive(1, 1, 1, 24'hFFF3FF);
    drive(1, 1, 1, 24'h000155);
    chk("R6 raw10 packed", out_data, 24'h1553FF);
    drive(1, 0, 0, 24'd0);
    drive(0, 0, 0, 24'd0);

    // R10 configuration frozen during frame
    idle_cfg(4'd0, 2'd0);
    drive(1, 0, 0, 24'd0);
    cfg_fmt = 4'd4; cfg_bus = 2'd2;
    drive(1, 1, 1, 24'hA1B2C3);
    chk("R10 old cfg kept", out_data, 24'h0000C3);
    drive(1, 0, 0, 24'd0);
    drive(0, 0, 0, 24'd0);
    drive(0, 0, 0, 24'd0);
    drive(1, 1, 1, 24'hA1B2C3);
    chk("R10 new cfg applied", out_data, 24'hA1B2C3);
    drive(1, 0, 0, 24'd0);
    drive(0, 0, 0, 24'd0);

    finish_up();
  end
endmodule